// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag and line-state store of a set-associative cache and decides the outcome of every request made against it. Each line holds a tag, a valid bit, a reserved bit, a dirty bit and a timestamp taken from a free-running cycle counter. The block has three request types. A lookup resolves an address as a hit, a hit-under-miss, a miss or a refused reservation. A fill installs a returning line. A flush invalidates the whole store and reports how many modified lines it dropped. Line data, the memory-side port and the write buffer live elsewhere.

In a write-back configuration, a read miss claims a way ahead of time so that the line has a slot when it returns from memory. If the claimed slot held modified data, the address of that old line is returned for write-back. Replacement is least-recently-used by timestamp. A write-through configuration never reserves: a hit there carries its own code so that the write still goes on to memory. The caller issues one request at a time with a valid/ready pair and gets a registered response one cycle later.

Top module: `cache_tag_ctrl`

## Requirements
- R1: An address splits into a byte offset in its low log2(LINE_BYTES) bits, a set index in the next log2(SETS) bits, and a tag in all the bits above. The offset never affects the outcome.
- R2: A lookup whose tag matches a valid, unreserved way is a hit. The code is 0 in write-back mode and 1 in write-through mode. The hit refreshes the way's timestamp, and a write hit marks the line dirty.
- R3: A lookup whose tag matches a reserved way returns code 2 (pending). It does this for reads and writes alike and changes no state.
- R4: A write-back read miss where some unreserved way is not dirty-valid reserves the lowest-numbered such way. It returns code 3 with no write-back.
- R5: A write-back read miss where every unreserved way is dirty-valid reserves the way with the smallest timestamp, with ties going to the lowest way. It returns code 3 and the evicted line's address (tag and set, offset zero) with the write-back flag set.
- R6: A write-back read miss where every way of the set is reserved returns code 5 (reservation refused). It changes no state and reports no write-back.
- R7: A miss on a write, or any miss in write-through mode, returns code 4 and reserves nothing.
- R8: A fill whose tag matches a reserved way turns that way into a valid, clean line. It returns code 6 with no write-back.
- R9: A fill whose tag matches a valid line is discarded. It returns code 7 with no write-back and leaves the line unchanged.
- R10: Any other fill takes the lowest free way. If no way is free, it replaces the unreserved way with the smallest timestamp and returns code 6. The write-back flag and address are given only if the replaced line was dirty. A fill to a set whose ways are all reserved returns code 7.
- R11: A flush visits one line per cycle, so req_ready stays low for SETS*WAYS cycles. It clears valid and dirty on every line and keeps reservations. It ends with a one-cycle flush_done, and flush_count holds the number of lines that were both valid and dirty.
- R12: rsp_valid is high for exactly one cycle, the cycle after an accepted lookup or fill. rsp_wb_addr is all ones whenever rsp_wb_valid is low.
- R13: Reset clears every valid, reserved and dirty bit. After reset req_ready is high and rsp_valid and flush_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (low during a flush) |
| req_op | input | 2 | 0 lookup, 1 fill, 2 flush |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | Lookup is a write |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 3 | Outcome code (see requirements) |
| rsp_wb_valid | output | 1 | A dirty line was displaced |
| rsp_wb_addr | output | ADDR_W | Displaced line address, all ones when none |
| flush_done | output | 1 | Flush finished (one-cycle pulse) |
| flush_count | output | clog2(SETS*WAYS+1) | Dirty lines dropped by the last flush |

## Verification
The end of a flush and the acceptance of the next lookup fall in the same cycle: req_ready rises together with flush_done, so a request held pending during the walk is taken at that very edge. The bench keeps a lookup asserted for the whole flush and counts the cycles with ready low. It then checks the reported dirty count and confirms that the held lookup sees the store already cleared, so it reserves instead of hitting. A reservation made before the flush must still report pending after it.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

   typedef enum logic [1:0] {
      OP_LOOKUP = 2'd0,
      OP_FILL   = 2'd1,
      OP_FLUSH  = 2'd2
   } ctc_op_e;

   typedef enum logic [2:0] {
      RC_HIT        = 3'd0,
      RC_HIT_WT     = 3'd1,
      RC_PENDING    = 3'd2,
      RC_MISS_RESV  = 3'd3,
      RC_MISS_NOALC = 3'd4,
      RC_RESV_FAIL  = 3'd5,
      RC_FILL_DONE  = 3'd6,
      RC_FILL_DROP  = 3'd7
   } ctc_code_e;

endpackage

// File: rtl/ctc_first_one.sv
module ctc_first_one #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
)(
   input  logic [N-1:0]  mask,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/ctc_lru_pick.sv
module ctc_lru_pick #(
   parameter int N  = 4,
   parameter int TW = 16,
   localparam int IW = (N > 1) ? $clog2(N) : 1
)(
   input  logic [N-1:0]         mask,
   input  logic [N-1:0][TW-1:0] stamp,
   output logic                 any,
   output logic [IW-1:0]        idx
);
   logic [TW-1:0] best;

   always_comb begin
      any  = 1'b0;
      idx  = '0;
      best = '0;
      for (int i = 0; i < N; i++) begin
         // strict compare: equal stamps keep the lower way
         if (mask[i] && (!any || stamp[i] < best)) begin
            any  = 1'b1;
            idx  = IW'(i);
            best = stamp[i];
         end
      end
   end
endmodule

// File: rtl/ctc_flush_walk.sv
module ctc_flush_walk #(
   parameter int LINES = 8,
   localparam int LW = (LINES > 1) ? $clog2(LINES) : 1,
   localparam int CW = $clog2(LINES + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          line_dirty,
   output logic          busy,
   output logic [LW-1:0] line_idx,
   output logic          done,
   output logic [CW-1:0] count
);
   localparam logic [LW-1:0] LAST = LW'(LINES - 1);

   logic [CW-1:0] acc_q;
   logic [CW-1:0] acc_next;

   assign acc_next = acc_q + CW'(line_dirty);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         line_idx <= '0;
         acc_q    <= '0;
         done     <= 1'b0;
         count    <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy     <= 1'b1;
            line_idx <= '0;
            acc_q    <= '0;
         end else if (busy) begin
            acc_q    <= acc_next;
            line_idx <= line_idx + 1'b1;
            if (line_idx == LAST) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               count <= acc_next;
            end
         end
      end
   end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
   import cache_tag_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int LINE_BYTES = 16,
   parameter int SETS       = 4,
   parameter int WAYS       = 2,
   parameter int TS_W       = 16,
   parameter bit WRITE_BACK = 1'b1
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_valid,
   output logic                           req_ready,
   input  logic [1:0]                     req_op,
   input  logic [ADDR_W-1:0]              req_addr,
   input  logic                           req_write,
   output logic                           rsp_valid,
   output logic [2:0]                     rsp_code,
   output logic                           rsp_wb_valid,
   output logic [ADDR_W-1:0]              rsp_wb_addr,
   output logic                           flush_done,
   output logic [$clog2(SETS*WAYS+1)-1:0] flush_count
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int WAY_W  = $clog2(WAYS);
   localparam int LINES  = SETS * WAYS;
   localparam int LINE_W = $clog2(LINES);
   localparam int CNT_W  = $clog2(LINES + 1);

   // elaboration-time parameter checks
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (LINE_BYTES < 2 || (1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W leaves no tag bits");
   end

   // ---------------- line store ----------------
   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [TS_W-1:0]  ts_q  [SETS][WAYS];
   logic [WAYS-1:0]  vld_q [SETS];
   logic [WAYS-1:0]  rsv_q [SETS];
   logic [WAYS-1:0]  drt_q [SETS];
   logic [TS_W-1:0]  now_q;

   // ---------------- request decode ----------------
   logic             acc;
   logic             acc_lk;
   logic             acc_fl;
   logic             acc_fs;
   logic [IDX_W-1:0] set_i;
   logic [TAG_W-1:0] tag_i;

   assign set_i  = req_addr[OFF_W +: IDX_W];
   assign tag_i  = req_addr[ADDR_W-1 -: TAG_W];
   assign acc    = req_valid && req_ready;
   assign acc_lk = acc && (req_op == OP_LOOKUP);
   assign acc_fl = acc && (req_op == OP_FILL);
   assign acc_fs = acc && (req_op == OP_FLUSH);

   // ---------------- per-way classification ----------------
   logic [WAYS-1:0]            m_hit;
   logic [WAYS-1:0]            m_pend;
   logic [WAYS-1:0]            m_clean;
   logic [WAYS-1:0]            m_free;
   logic [WAYS-1:0]            m_cand;
   logic [WAYS-1:0][TS_W-1:0]  stamp_w;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic same_tag;
      assign same_tag   = (tag_q[set_i][w] == tag_i);
      assign m_hit[w]   = vld_q[set_i][w] && !rsv_q[set_i][w] && same_tag;
      assign m_pend[w]  = rsv_q[set_i][w] && same_tag;
      assign m_clean[w] = !rsv_q[set_i][w] && !(vld_q[set_i][w] && drt_q[set_i][w]);
      assign m_free[w]  = !rsv_q[set_i][w] && !vld_q[set_i][w];
      assign m_cand[w]  = vld_q[set_i][w] && !rsv_q[set_i][w];
      assign stamp_w[w] = ts_q[set_i][w];
   end

   logic             hit_any,   pend_any,   clean_any,   free_any,   cand_any;
   logic [WAY_W-1:0] hit_way,   pend_way,   clean_way,   free_way,   lru_way;

   ctc_first_one #(.N(WAYS)) u_hit   (.mask(m_hit),   .any(hit_any),   .idx(hit_way));
   ctc_first_one #(.N(WAYS)) u_pend  (.mask(m_pend),  .any(pend_any),  .idx(pend_way));
   ctc_first_one #(.N(WAYS)) u_clean (.mask(m_clean), .any(clean_any), .idx(clean_way));
   ctc_first_one #(.N(WAYS)) u_free  (.mask(m_free),  .any(free_any),  .idx(free_way));
   ctc_lru_pick  #(.N(WAYS), .TW(TS_W)) u_lru (
      .mask(m_cand), .stamp(stamp_w), .any(cand_any), .idx(lru_way)
   );

   // ---------------- write policy variant ----------------
   logic      may_reserve;
   ctc_code_e hit_code;

   if (WRITE_BACK) begin : g_wb
      assign may_reserve = !req_write;
      assign hit_code    = RC_HIT;
   end else begin : g_wt
      assign may_reserve = 1'b0;
      assign hit_code    = RC_HIT_WT;
   end

   // ---------------- decision ----------------
   ctc_code_e        code_c;
   logic             wbv_c;
   logic [ADDR_W-1:0] wba_c;
   logic             wr_en;
   logic [WAY_W-1:0] wr_way;
   logic             nv, nr, nd, wr_ts;
   logic [ADDR_W-1:0] lru_line_addr;

   assign lru_line_addr = {tag_q[set_i][lru_way], set_i, {OFF_W{1'b0}}};

   always_comb begin
      code_c = RC_HIT;
      wbv_c  = 1'b0;
      wba_c  = '1;
      wr_en  = 1'b0;
      wr_way = '0;
      nv     = 1'b0;
      nr     = 1'b0;
      nd     = 1'b0;
      wr_ts  = 1'b0;
      if (acc_lk) begin
         if (pend_any) begin
            code_c = RC_PENDING;
         end else if (hit_any) begin
            code_c = hit_code;
            wr_en  = 1'b1;
            wr_way = hit_way;
            nv     = 1'b1;
            nd     = drt_q[set_i][hit_way] | req_write;
            wr_ts  = 1'b1;
         end else if (!may_reserve) begin
            code_c = RC_MISS_NOALC;
         end else if (&rsv_q[set_i]) begin
            code_c = RC_RESV_FAIL;
         end else if (clean_any) begin
            code_c = RC_MISS_RESV;
            wr_en  = 1'b1;
            wr_way = clean_way;
            nr     = 1'b1;
         end else begin
            code_c = RC_MISS_RESV;
            wr_en  = 1'b1;
            wr_way = lru_way;
            nr     = 1'b1;
            wbv_c  = 1'b1;
            wba_c  = lru_line_addr;
         end
      end else if (acc_fl) begin
         if (pend_any) begin
            code_c = RC_FILL_DONE;
            wr_en  = 1'b1;
            wr_way = pend_way;
            nv     = 1'b1;
            wr_ts  = 1'b1;
         end else if (hit_any) begin
            code_c = RC_FILL_DROP;
         end else if (free_any) begin
            code_c = RC_FILL_DONE;
            wr_en  = 1'b1;
            wr_way = free_way;
            nv     = 1'b1;
            wr_ts  = 1'b1;
         end else if (cand_any) begin
            code_c = RC_FILL_DONE;
            wr_en  = 1'b1;
            wr_way = lru_way;
            nv     = 1'b1;
            wr_ts  = 1'b1;
            if (drt_q[set_i][lru_way]) begin
               wbv_c = 1'b1;
               wba_c = lru_line_addr;
            end
         end else begin
            code_c = RC_FILL_DROP;
         end
      end
   end

   // ---------------- flush walker ----------------
   logic              f_busy;
   logic [LINE_W-1:0] f_idx;
   logic [IDX_W-1:0]  f_set;
   logic [WAY_W-1:0]  f_way;
   logic              f_dirty;

   assign f_set   = f_idx[LINE_W-1:WAY_W];
   assign f_way   = f_idx[WAY_W-1:0];
   assign f_dirty = vld_q[f_set][f_way] & drt_q[f_set][f_way];

   ctc_flush_walk #(.LINES(LINES)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (acc_fs),
      .line_dirty (f_dirty),
      .busy       (f_busy),
      .line_idx   (f_idx),
      .done       (flush_done),
      .count      (flush_count)
   );

   assign req_ready = !f_busy;

   // ---------------- state and response registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_q        <= '0;
         rsp_valid    <= 1'b0;
         rsp_code     <= '0;
         rsp_wb_valid <= 1'b0;
         rsp_wb_addr  <= '1;
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            rsv_q[s] <= '0;
            drt_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) begin
               tag_q[s][w] <= '0;
               ts_q[s][w]  <= '0;
            end
         end
      end else begin
         now_q     <= now_q + 1'b1;
         rsp_valid <= acc_lk || acc_fl;
         if (acc_lk || acc_fl) begin
            rsp_code     <= code_c;
            rsp_wb_valid <= wbv_c;
            rsp_wb_addr  <= wba_c;
         end
         if (f_busy) begin
            vld_q[f_set][f_way] <= 1'b0;
            drt_q[f_set][f_way] <= 1'b0;
         end
         if (wr_en) begin
            tag_q[set_i][wr_way] <= tag_i;
            vld_q[set_i][wr_way] <= nv;
            rsv_q[set_i][wr_way] <= nr;
            drt_q[set_i][wr_way] <= nd;
            if (wr_ts) ts_q[set_i][wr_way] <= now_q;
         end
      end
   end
endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk
   import cache_tag_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LINES  = 8
)(
   input logic                       clk,
   input logic                       rst_n,
   input logic                       req_valid,
   input logic                       req_ready,
   input logic [1:0]                 req_op,
   input logic                       rsp_valid,
   input logic [2:0]                 rsp_code,
   input logic                       rsp_wb_valid,
   input logic [ADDR_W-1:0]          rsp_wb_addr,
   input logic                       flush_done,
   input logic [$clog2(LINES+1)-1:0] flush_count
);
   logic take_rsp;
   assign take_rsp = req_valid && req_ready && (req_op == OP_LOOKUP || req_op == OP_FILL);

   a_r12_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      take_rsp |=> rsp_valid);
   a_r12_no_rsp_unasked: assert property (@(posedge clk) disable iff (!rst_n)
      !take_rsp |=> !rsp_valid);
   a_r12_none_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_wb_valid) |-> (&rsp_wb_addr));
   a_r11_busy_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op == OP_FLUSH) |=> !req_ready);
   a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |=> !flush_done);
   a_r11_done_frees_port: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |-> req_ready);
   a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |-> (int'(flush_count) <= LINES));
   a_r5_wb_kinds: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_wb_valid) |-> (rsp_code == RC_MISS_RESV || rsp_code == RC_FILL_DONE));
   a_r6_fail_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == RC_RESV_FAIL) |-> !rsp_wb_valid);
endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .LINES  (SETS * WAYS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_op       (req_op),
   .rsp_valid    (rsp_valid),
   .rsp_code     (rsp_code),
   .rsp_wb_valid (rsp_wb_valid),
   .rsp_wb_addr  (rsp_wb_addr),
   .flush_done   (flush_done),
   .flush_count  (flush_count)
);

// File: tb/tb_cache_tag_ctrl.sv
module tb_cache_tag_ctrl;
   localparam int ADDR_W = 16;
   localparam int CNT_W  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic              req_valid = 1'b0;
   logic [1:0]        req_op = 2'd0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_write = 1'b0;

   logic              rdy, rv, wbv, fd;
   logic [2:0]        code;
   logic [ADDR_W-1:0] wba;
   logic [CNT_W-1:0]  fc;
   logic              w_rdy, w_rv, w_wbv, w_fd;
   logic [2:0]        w_code;
   logic [ADDR_W-1:0] w_wba;
   logic [CNT_W-1:0]  w_fc;

   cache_tag_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy),
      .req_op(req_op), .req_addr(req_addr), .req_write(req_write),
      .rsp_valid(rv), .rsp_code(code), .rsp_wb_valid(wbv), .rsp_wb_addr(wba),
      .flush_done(fd), .flush_count(fc)
   );

   cache_tag_ctrl #(.WRITE_BACK(1'b0)) dut_wt (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(w_rdy),
      .req_op(req_op), .req_addr(req_addr), .req_write(req_write),
      .rsp_valid(w_rv), .rsp_code(w_code), .rsp_wb_valid(w_wbv), .rsp_wb_addr(w_wba),
      .flush_done(w_fd), .flush_count(w_fc)
   );

   int checks = 0;
   int errors = 0;

   // address: tag 10 bits | set 2 bits | offset 4 bits
   function automatic logic [ADDR_W-1:0] la(input int tag, input int set, input int off);
      return {10'(tag), 2'(set), 4'(off)};
   endfunction

   // entry: op, write, tag, set, offset, code, wb flag, wb tag, requirement
   typedef struct packed {
      logic [1:0] op;
      logic       wr;
      logic [9:0] tag;
      logic [1:0] set;
      logic [3:0] off;
      logic [2:0] code;
      logic       wbv;
      logic [9:0] wbt;
      logic [3:0] rq;
   } vec_t;

   function automatic vec_t mk(input int op, input int wr, input int tag, input int set,
                               input int off, input int c, input int w, input int wt, input int rq);
      vec_t v;
      v.op = 2'(op); v.wr = 1'(wr); v.tag = 10'(tag); v.set = 2'(set); v.off = 4'(off);
      v.code = 3'(c); v.wbv = 1'(w); v.wbt = 10'(wt); v.rq = 4'(rq);
      return v;
   endfunction

   localparam int NV = 28;
   localparam vec_t VEC [NV] = '{
      mk(0,0, 5,1,0, 3,0,0, 4),   // R4 first miss reserves way0
      mk(0,0, 5,1,0, 2,0,0, 3),   // R3 read to reserved line
      mk(0,1, 5,1,0, 2,0,0, 3),   // R3 write to reserved line
      mk(0,0, 6,1,0, 3,0,0, 4),   // R4 reserves way1
      mk(0,0, 7,1,0, 5,0,0, 6),   // R6 both ways reserved
      mk(1,0, 5,1,0, 6,0,0, 8),   // R8 completes reservation
      mk(1,0, 6,1,0, 6,0,0, 8),   // R8
      mk(1,0, 6,1,0, 7,0,0, 9),   // R9 duplicate fill dropped
      mk(0,0, 5,1,0, 0,0,0, 2),   // R2 read hit
      mk(0,1, 6,1,0, 0,0,0, 2),   // R2 write hit, way1 dirty
      mk(0,1, 5,1,0, 0,0,0, 2),   // R2 write hit, way0 dirty and newest
      mk(0,0, 7,1,0, 3,1,6, 5),   // R5 LRU dirty victim tag 6
      mk(0,1, 8,1,0, 4,0,0, 7),   // R7 write miss no allocation
      mk(1,0, 9,1,0, 6,1,5,10),   // R10 dirty victim returned
      mk(1,0,10,1,0, 6,0,0,10),   // R10 clean victim, no writeback
      mk(1,0, 7,1,0, 6,0,0, 8),   // R8 reservation from vector 12
      mk(1,0,11,2,0, 6,0,0,10),   // R10 free way
      mk(0,0,11,2,0, 0,0,0, 2),   // R2
      mk(0,0,11,3,0, 3,0,0, 1),   // R1 other set misses
      mk(0,0,11,2,15,0,0,0, 1),   // R1 offset ignored
      mk(1,0, 1,0,0, 6,0,0,10),   // R10
      mk(1,0, 2,0,0, 6,0,0,10),   // R10
      mk(1,0, 3,0,0, 6,0,0,10),   // R10 LRU replaces tag 1 in way0
      mk(0,0, 1,0,0, 3,0,0, 4),   // R4 clean way0 taken
      mk(0,0, 3,0,0, 3,0,0, 4),   // R4 clean way1 taken
      mk(0,0, 2,0,0, 5,0,0, 6),   // R6
      mk(0,1,10,1,0, 0,0,0, 2),   // R2 dirty for flush
      mk(0,1,11,2,0, 0,0,0, 2)    // R2 dirty for flush
   };

   task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [ADDR_W-1:0] a, input logic w);
      req_valid = 1'b1; req_op = op; req_addr = a; req_write = w;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R13 reset state
      check(rdy && !rv && !fd, "R13", {29'd0, rdy, rv, fd}, 32'd4);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [ADDR_W-1:0] exp_a;
         logic [31:0] act, exp;
         issue(VEC[i].op, la(VEC[i].tag, VEC[i].set, VEC[i].off), VEC[i].wr);
         exp_a = VEC[i].wbv ? la(VEC[i].wbt, VEC[i].set, 0) : '1;
         act = {11'd0, rv, code, wbv, wba};
         exp = {11'd0, 1'b1, VEC[i].code, VEC[i].wbv, exp_a};
         check(act == exp, $sformatf("R%0d vec%0d", VEC[i].rq, i), act, exp);
         // R12 response is one cycle only
         @(negedge clk);
         check(!rv, "R12 single", {31'd0, rv}, 32'd0);
      end

      // R11 flush with a lookup held pending across it
      begin
         int lowc = 0;
         req_valid = 1'b1; req_op = 2'd2; req_addr = '0; req_write = 1'b0;
         @(posedge clk);
         @(negedge clk);
         req_op = 2'd0; req_addr = la(10, 1, 0);
         while (!fd && lowc < 50) begin
            if (!rdy) lowc++;
            if (rv) check(1'b0, "R11 no rsp during flush", 32'd1, 32'd0);
            @(negedge clk);
         end
         check(lowc == 8, "R11 busy cycles", lowc, 8);
         check(fd && fc == 4'd2, "R11 dirty count", {27'd0, fd, fc}, 32'h12);
         check(rdy, "R11 ready with done", {31'd0, rdy}, 32'd1);
         @(posedge clk);
         @(negedge clk);
         req_valid = 1'b0;
         check(rv && code == 3'd3 && !wbv, "R11 lookup sees cleared store",
               {28'd0, rv, code}, 32'hB);
         check(!fd, "R11 done pulse", {31'd0, fd}, 32'd0);
         issue(2'd0, la(1, 0, 0), 1'b0);
         check(code == 3'd2, "R11 reservation kept", {29'd0, code}, 32'd2);
      end

      // R13 reset clears reservations
      rst_n = 1'b0;
      @(negedge clk);
      check(rdy && !rv, "R13 reset again", {30'd0, rdy, rv}, 32'd2);
      rst_n = 1'b1;
      @(negedge clk);
      issue(2'd0, la(1, 0, 0), 1'b0);
      check(code == 3'd3, "R13 no stale reservation", {29'd0, code}, 32'd3);
      // write-through instance: R2 and R7
      issue(2'd1, la(5, 2, 0), 1'b0);
      check(w_rv && w_code == 3'd6, "R10 wt fill", {28'd0, w_rv, w_code}, 32'hE);
      issue(2'd0, la(5, 2, 0), 1'b0);
      check(w_code == 3'd1, "R2 wt hit code", {29'd0, w_code}, 32'd1);
      issue(2'd0, la(6, 2, 0), 1'b0);
      check(w_code == 3'd4 && w_wba == '1, "R7 wt miss", {29'd0, w_code}, 32'd4);
      issue(2'd0, la(6, 2, 0), 1'b0);
      check(w_code == 3'd4, "R7 wt no reservation", {29'd0, w_code}, 32'd4);
      summary();
   end
endmodule